// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves the move-to and move-from special-register operations of a small RISC core. Each access carries a base value and a 16-bit immediate. The block combines the two into a register address by bitwise OR, not by addition. The top five address bits select a register group, and the low eleven bits select a register within that group.

Group 0 is held locally. It contains five read-only identity and configuration words and six supervision registers that software can read and write: status, next PC, previous PC, exception PC, exception effective address and exception status. The block exports the two translation-enable bits of the status register as levels for the MMUs. It also pulses a flush when a status write changes the protection or translation mode.

Accesses to groups 1, 2, 9 and 10 are forwarded to external blocks through a one-hot strobe, together with the low address bits. Access is a valid-only stream. Every request with `acc_valid` high is accepted at the next rising edge, so there is no back-pressure. A read produces exactly one response beat one cycle later. A write produces none.

Top module: `spr_access_unit`

## Requirements
- R1: The register address is `base_val | imm_off`, computed bitwise over 16 bits, and never their sum.
- R2: The group is address bits [15:11] and the register number is bits [10:0]. A group-3 address whose number is 17 does not reach the status register.
- R3: Group-0 numbers 1, 2, 3 and 4 return the parameters UPR_WORD (default 32'h0000_0619), CPU_WORD (32'h0000_0020), DMMU_WORD (32'h0000_0018) and IMMU_WORD (32'h0000_0019). Writes to numbers 0 to 4 are ignored.
- R4: Group-0 numbers 16, 18, 32, 48 and 64 are 32-bit registers. A write is returned by the next read of the same number. Reset value is 0.
- R5: Status is group-0 number 17. After any write, bit 15 of the status register reads 1 and the other bits read as written.
- R6: A status write that changes bit 0 (supervisor), bit 5 (data translation) or bit 6 (instruction translation) drives `tlb_flush` high for exactly the cycle after the write. A status write that leaves all three bits unchanged does not.
- R7: `dmmu_on` equals status bit 5 and `immu_on` equals status bit 6, as levels.
- R8: A read of an unimplemented address returns `old_rd` unchanged. This includes group-0 numbers other than 0 to 4, 16, 17, 18, 32, 48 and 64, and groups other than 0, 1, 2, 9 and 10.
- R9: A read of group-0 number 0 returns VER_WORD & VER_MASK (default 32'h1200_0345 & 32'hFFFF_003F = 32'h1200_0005).
- R10: An access in group 1, 2, 9 or 10 raises `ext_sel` bit 0, 1, 2 or 3 respectively, and no other bit, in the same cycle. In that cycle `ext_addr` holds address bits [10:0] and `ext_we` equals `acc_write`. A read returns `ext_rdata` as sampled in that cycle.
- R11: After reset the status register reads 32'h0000_8001, `immu_on` and `dmmu_on` are 0, and neither `rsp_valid` nor `tlb_flush` is high.
- R12: A read accepted at an edge gives `rsp_valid` high for one cycle after that edge. A write gives no response beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request, always accepted |
| acc_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| base_val | input | 16 | Low bits of the base register |
| imm_off | input | 16 | Immediate offset |
| wdata | input | 32 | Write data |
| old_rd | input | 32 | Current destination value, returned for unmapped reads |
| rsp_valid | output | 1 | Read response beat |
| rsp_data | output | 32 | Read response data |
| ext_sel | output | 4 | One-hot strobe for groups 1, 2, 9, 10 |
| ext_addr | output | 11 | Register number for external group |
| ext_we | output | 1 | Write qualifier for external group |
| ext_wdata | output | 32 | Write data to external group |
| ext_rdata | input | 32 | Read data from external group |
| immu_on | output | 1 | Instruction translation enabled |
| dmmu_on | output | 1 | Data translation enabled |
| tlb_flush | output | 1 | One-cycle translation flush pulse |

## Verification
Address formation is tried with a base and an immediate whose OR and sum fall on different registers, which separates the two ways of combining them. The status register is written with patterns that flip each mode bit on its own, that repeat the current mode, and that clear the fixed-one bit; these separate a real mode change from a mere write. The bench reads every mapped and unmapped class of address, and this tells apart local storage, constant words, external forwarding and the pass-through of the old destination value.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int NUM_W   = 11;
  localparam int GRP_W   = ADDR_W - NUM_W;
  localparam int N_PLAIN = 5;
  localparam int N_EXT   = 4;

  localparam int SR_SUP  = 0;
  localparam int SR_DTR  = 5;
  localparam int SR_ITR  = 6;
  localparam int SR_ONE  = 15;
  localparam logic [DATA_W-1:0] SR_MODE_MASK =
    (DATA_W'(1) << SR_SUP) | (DATA_W'(1) << SR_DTR) | (DATA_W'(1) << SR_ITR);
  localparam logic [DATA_W-1:0] SR_RESET =
    (DATA_W'(1) << SR_SUP) | (DATA_W'(1) << SR_ONE);

  localparam logic [GRP_W-1:0] EXT_GRP [N_EXT] = '{5'd1, 5'd2, 5'd9, 5'd10};

  typedef enum logic [2:0] {
    K_NONE, K_ID, K_PLAIN, K_SR, K_EXT
  } spr_kind_e;
endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
(
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] imm_off,
  output spr_kind_e         kind,
  output logic [2:0]        sub,
  output logic [N_EXT-1:0]  grp_hit,
  output logic [NUM_W-1:0]  num
);
  logic [ADDR_W-1:0] addr;
  logic [GRP_W-1:0]  grp;

  assign addr = base_val | imm_off;
  assign grp  = addr[ADDR_W-1:NUM_W];
  assign num  = addr[NUM_W-1:0];

  always_comb begin
    kind    = K_NONE;
    sub     = '0;
    grp_hit = '0;
    if (grp == '0) begin
      case (num)
        11'd0, 11'd1, 11'd2, 11'd3, 11'd4: begin kind = K_ID; sub = num[2:0]; end
        11'd16: begin kind = K_PLAIN; sub = 3'd0; end
        11'd17: kind = K_SR;
        11'd18: begin kind = K_PLAIN; sub = 3'd1; end
        11'd32: begin kind = K_PLAIN; sub = 3'd2; end
        11'd48: begin kind = K_PLAIN; sub = 3'd3; end
        11'd64: begin kind = K_PLAIN; sub = 3'd4; end
        default: kind = K_NONE;
      endcase
    end else begin
      for (int i = 0; i < N_EXT; i++) begin
        if (grp == EXT_GRP[i]) begin
          kind       = K_EXT;
          grp_hit[i] = 1'b1;
        end
      end
    end
  end

  assert_grp_onehot_R10: assert final ($onehot0(grp_hit));
endmodule

// File: rtl/spr_regs.sv
module spr_regs
  import spr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  spr_kind_e                     kind,
  input  logic [2:0]                    sub,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             sr_q,
  output logic [N_PLAIN-1:0][DATA_W-1:0] plain_q,
  output logic                          tlb_flush
);
  logic sr_we;
  assign sr_we = wr_en && (kind == K_SR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q      <= SR_RESET;
      tlb_flush <= 1'b0;
    end else begin
      tlb_flush <= sr_we && (((sr_q ^ wdata) & SR_MODE_MASK) != '0);
      if (sr_we) sr_q <= wdata | (DATA_W'(1) << SR_ONE);
    end
  end

  for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
    always_ff @(posedge clk) begin
      if (!rst_n)
        plain_q[i] <= '0;
      else if (wr_en && kind == K_PLAIN && sub == 3'(i))
        plain_q[i] <= wdata;
    end
  end

  assert_flush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> $past(sr_we));
  assert_fixed_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q[SR_ONE]);
endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter logic [31:0] VER_WORD  = 32'h1200_0345,
  parameter logic [31:0] VER_MASK  = 32'hFFFF_003F,
  parameter logic [31:0] UPR_WORD  = 32'h0000_0619,
  parameter logic [31:0] CPU_WORD  = 32'h0000_0020,
  parameter logic [31:0] DMMU_WORD = 32'h0000_0018,
  parameter logic [31:0] IMMU_WORD = 32'h0000_0019
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [15:0]       base_val,
  input  logic [15:0]       imm_off,
  input  logic [31:0]       wdata,
  input  logic [31:0]       old_rd,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic [3:0]        ext_sel,
  output logic [10:0]       ext_addr,
  output logic              ext_we,
  output logic [31:0]       ext_wdata,
  input  logic [31:0]       ext_rdata,
  output logic              immu_on,
  output logic              dmmu_on,
  output logic              tlb_flush
);
  spr_kind_e                      kind;
  logic [2:0]                     sub;
  logic [N_EXT-1:0]               grp_hit;
  logic [NUM_W-1:0]               num;
  logic [DATA_W-1:0]              sr_q;
  logic [N_PLAIN-1:0][DATA_W-1:0] plain_q;
  logic [DATA_W-1:0]              rd_mux;
  logic [DATA_W-1:0]              id_word;

  spr_decode u_dec (
    .base_val(base_val), .imm_off(imm_off),
    .kind(kind), .sub(sub), .grp_hit(grp_hit), .num(num)
  );

  spr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(acc_valid && acc_write),
    .kind(kind), .sub(sub), .wdata(wdata),
    .sr_q(sr_q), .plain_q(plain_q), .tlb_flush(tlb_flush)
  );

  assign ext_sel   = acc_valid ? grp_hit : '0;
  assign ext_addr  = num;
  assign ext_we    = acc_valid && acc_write && (kind == K_EXT);
  assign ext_wdata = wdata;
  assign immu_on   = sr_q[SR_ITR];
  assign dmmu_on   = sr_q[SR_DTR];

  always_comb begin
    case (sub)
      3'd0:    id_word = VER_WORD & VER_MASK;
      3'd1:    id_word = UPR_WORD;
      3'd2:    id_word = CPU_WORD;
      3'd3:    id_word = DMMU_WORD;
      default: id_word = IMMU_WORD;
    endcase
  end

  always_comb begin
    case (kind)
      K_ID:    rd_mux = id_word;
      K_PLAIN: rd_mux = plain_q[sub];
      K_SR:    rd_mux = sr_q;
      K_EXT:   rd_mux = ext_rdata;
      default: rd_mux = old_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rsp_data <= rd_mux;
    end
  end

  assert_rsp_beat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_valid && !acc_write));
  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_sel));
  assert_mmu_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid && acc_write && kind == K_SR) |-> ($stable(immu_on) && $stable(dmmu_on)));
  assert_ext_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> (ext_sel != '0));
endmodule

// File: tb/sim_spr_access_unit.sv
module sim_spr_access_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [15:0] base_val = '0, imm_off = '0;
  logic [31:0] wdata = '0, old_rd = '0, ext_rdata = 32'hA5A5_0001;
  logic rsp_valid, ext_we, immu_on, dmmu_on, tlb_flush;
  logic [31:0] rsp_data, ext_wdata;
  logic [3:0] ext_sel;
  logic [10:0] ext_addr;
  int checks = 0, fails = 0;
  logic [31:0] got_rsp;
  logic got_v, got_we;
  logic [3:0] got_sel;
  logic [10:0] got_eaddr;

  always #10 clk = ~clk;

  spr_access_unit u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [15:0] b, input logic [15:0] i,
                     input logic [31:0] d, input logic [31:0] o);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; base_val = b; imm_off = i; wdata = d; old_rd = o;
    #1;
    got_sel = ext_sel; got_eaddr = ext_addr; got_we = ext_we;
    @(posedge clk); #1;
    got_v = rsp_valid; got_rsp = rsp_data;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] o);
    acc(1'b0, a, 16'h0, 32'h0, o);
  endtask

  task automatic t_reset;
    chk("R11 rsp_valid", {31'b0, rsp_valid}, 0);
    chk("R11 immu_on", {31'b0, immu_on}, 0);
    chk("R11 dmmu_on", {31'b0, dmmu_on}, 0);
    chk("R11 tlb_flush", {31'b0, tlb_flush}, 0);
    rd(16'd17, 32'h0);
    chk("R11 status", got_rsp, 32'h0000_8001);
    chk("R12 read beat", {31'b0, got_v}, 1);
  endtask

  task automatic t_ident;
    rd(16'd0, 32'h0); chk("R9 version", got_rsp, 32'h1200_0005);
    rd(16'd1, 32'h0); chk("R3 upr", got_rsp, 32'h0000_0619);
    rd(16'd2, 32'h0); chk("R3 cpu", got_rsp, 32'h0000_0020);
    rd(16'd3, 32'h0); chk("R3 dmmu", got_rsp, 32'h0000_0018);
    rd(16'd4, 32'h0); chk("R3 immu", got_rsp, 32'h0000_0019);
    acc(1'b1, 16'd1, 16'h0, 32'hFFFF_FFFF, 32'h0);
    chk("R12 write no beat", {31'b0, got_v}, 0);
    rd(16'd1, 32'h0); chk("R3 write ignored", got_rsp, 32'h0000_0619);
  endtask

  task automatic t_plain;
    logic [15:0] nums [5] = '{16'd16, 16'd18, 16'd32, 16'd48, 16'd64};
    for (int k = 0; k < 5; k++) acc(1'b1, nums[k], 16'h0, 32'h1000_0000 + k, 32'h0);
    for (int k = 0; k < 5; k++) begin
      rd(nums[k], 32'h0);
      chk("R4 readback", got_rsp, 32'h1000_0000 + k);
    end
  endtask

  task automatic t_or;
    acc(1'b1, 16'h0012, 16'h0010, 32'h0BAD_F00D, 32'h0);
    rd(16'd18, 32'h0); chk("R1 or address", got_rsp, 32'h0BAD_F00D);
    rd(16'd34, 32'h7777_0000); chk("R1 sum not used", got_rsp, 32'h7777_0000);
  endtask

  task automatic t_status;
    acc(1'b1, 16'd17, 16'h0, 32'h0000_0001, 32'h0);
    chk("R6 no change no flush", {31'b0, tlb_flush}, 0);
    rd(16'd17, 32'h0); chk("R5 fixed one", got_rsp, 32'h0000_8001);
    acc(1'b1, 16'd17, 16'h0, 32'h0000_0041, 32'h0);
    chk("R6 flush on itr", {31'b0, tlb_flush}, 1);
    chk("R7 immu_on", {31'b0, immu_on}, 1);
    chk("R7 dmmu_on", {31'b0, dmmu_on}, 0);
    @(posedge clk); #1;
    chk("R6 flush one cycle", {31'b0, tlb_flush}, 0);
    acc(1'b1, 16'd17, 16'h0, 32'h0000_0341, 32'h0);
    chk("R6 other bits no flush", {31'b0, tlb_flush}, 0);
    rd(16'd17, 32'h0); chk("R5 readback", got_rsp, 32'h0000_8341);
    acc(1'b1, 16'd17, 16'h0, 32'h0000_0021, 32'h0);
    chk("R6 flush on swap", {31'b0, tlb_flush}, 1);
    chk("R7 immu off", {31'b0, immu_on}, 0);
    chk("R7 dmmu on", {31'b0, dmmu_on}, 1);
    acc(1'b1, 16'd17, 16'h0, 32'h0000_0020, 32'h0);
    chk("R6 flush on sup", {31'b0, tlb_flush}, 1);
  endtask

  task automatic t_unmapped;
    rd(16'd5, 32'hDEAD_BEEF); chk("R8 group0 hole", got_rsp, 32'hDEAD_BEEF);
    rd(16'h1811, 32'h1234_5678); chk("R2 group3 num17", got_rsp, 32'h1234_5678);
    rd(16'd17, 32'h0); chk("R2 status intact", got_rsp, 32'h0000_8020);
  endtask

  task automatic t_ext;
    rd(16'h4802, 32'h0);
    chk("R10 sel g9", {28'b0, got_sel}, 32'h4);
    chk("R10 addr", {21'b0, got_eaddr}, 32'd2);
    chk("R10 rdata", got_rsp, 32'hA5A5_0001);
    acc(1'b1, 16'h0800, 16'h0205, 32'h1, 32'h0);
    chk("R10 sel g1", {28'b0, got_sel}, 32'h1);
    chk("R10 we", {31'b0, got_we}, 1);
    chk("R10 addr g1", {21'b0, got_eaddr}, 32'h205);
    rd(16'h5000, 32'h0); chk("R10 sel g10", {28'b0, got_sel}, 32'h8);
    rd(16'd16, 32'h0); chk("R10 group0 no sel", {28'b0, got_sel}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset; t_ident; t_plain; t_or; t_status; t_unmapped; t_ext;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule